// File: doc/BRIEF.md
# AHB-Lite to APB Bridge

This block is an AHB-Lite slave that turns every accepted AHB transfer into one access on a peripheral bus of the APB kind. At the accepting clock edge it latches the address and the direction. For a write it spends one more cycle capturing the write data, which the AHB master only presents in the data phase. It then runs a fixed two-phase peripheral access: a setup cycle with the decoded select high, followed by an enable cycle with the strobe high. The peripherals cannot stretch either phase.

While the peripheral access is in flight, the bridge holds its ready output low. This back-pressure stalls the AHB master. Read data from the selected peripheral is registered at the end of the enable cycle. It appears on the AHB read-data bus in the same cycle that ready returns high. A new transfer may be offered in that same cycle.

The sequencer has four named states: IDLE, WDATA (write-data capture), SETUP and ENABLE. Its transitions are:
- IDLE to SETUP, when a read is accepted.
- IDLE to WDATA, when a write is accepted.
- IDLE to IDLE, when nothing is accepted.
- WDATA to SETUP.
- SETUP to ENABLE.
- ENABLE to IDLE.

The cycle after ENABLE is the completion cycle of the AHB data phase. Any transfer accepted there goes directly to SETUP or WDATA, so back-to-back transfers lose no cycle beyond the fixed access.

Top module: `ahbl_apb_bridge`

## Requirements
- R1: After reset the bridge is in IDLE, ready_out is 1, all peripheral selects are 0, and the enable strobe is 0.
- R2: A transfer is accepted only when sel_in is 1, ready_in is 1, trans_in is 2 (NONSEQ) or 3 (SEQ), and the sequencer is in IDLE. An offer with trans_in 0 (IDLE), trans_in 1 (BUSY), sel_in low or ready_in low is ignored: ready_out stays 1 and no select rises.
- R3: For an accepted read, the cycle after acceptance is SETUP: exactly one select is high and the enable strobe is 0. The next cycle is ENABLE: the same select is high and the enable strobe is 1. The bridge is then back in IDLE with all selects 0.
- R4: For an accepted write, the cycle after acceptance is WDATA: all selects are 0 and ready_out is 0. SETUP and ENABLE follow it, as in R3.
- R5: The peripheral address equals the AHB address latched at acceptance. The peripheral address, the direction and the peripheral write data do not change between SETUP and ENABLE.
- R6: The select bit that rises is the one numbered by address bits [15:14] (two top bits of the default 16-bit address).
- R7: ready_out is 0 from the cycle after acceptance through the ENABLE cycle. It is 1 in the cycle after ENABLE.
- R8: On a read, the read data output shows the selected peripheral's read data as it was at the end of ENABLE, starting in the cycle ready_out returns to 1. A write leaves the read data output unchanged.
- R9: The peripheral write data equals the AHB write data presented in the cycle after the write's address phase.
- R10: The enable strobe is never 1 without exactly one select high, and at most one select is ever high.
- R11: A transfer offered in the cycle ready_out returns to 1 is accepted, and it enters SETUP (read) or WDATA (write) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both bus sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_in | input | 1 | AHB slave select for this bridge |
| addr_in | input | AW | AHB address |
| trans_in | input | 2 | AHB transfer type |
| write_in | input | 1 | AHB direction, 1 means write |
| wdata_in | input | DW | AHB write data (data phase) |
| ready_in | input | 1 | AHB bus ready seen by all slaves |
| ready_out | output | 1 | This slave's ready, low while busy |
| rdata_out | output | DW | Read data returned to AHB |
| per_sel | output | NPER | One-hot peripheral selects |
| per_en | output | 1 | Peripheral enable strobe |
| per_write | output | 1 | Peripheral direction |
| per_addr | output | AW | Peripheral address |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | NPER*DW | Read data of all peripherals, peripheral k in slice k |

## Verification
The bench uses the default parameters: a 16-bit address, a 32-bit data path and four peripherals. With these values the two top address bits reach every select line, and random low address bits show that only the top bits steer the decode. Each peripheral's read data slice gets a fresh random value before every transfer, so a wrong select or wrong sampling cycle shows up as a data mismatch. Random gaps of zero to two idle cycles mix back-to-back transfers with isolated ones. Directed offers cover each ignored case.

// File: rtl/ahbl_apb_pkg.sv
package ahbl_apb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WDATA  = 2'd1,
        ST_SETUP  = 2'd2,
        ST_ENABLE = 2'd3
    } brg_state_e;

    localparam logic [1:0] TR_IDLE   = 2'd0;
    localparam logic [1:0] TR_BUSY   = 2'd1;
    localparam logic [1:0] TR_NONSEQ = 2'd2;
    localparam logic [1:0] TR_SEQ    = 2'd3;

endpackage

// File: rtl/brg_sequencer.sv
module brg_sequencer
    import ahbl_apb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       acc_write,
    input  logic       lat_write,
    output brg_state_e state,
    output logic       ready_out,
    output logic       phase_on,
    output logic       strobe,
    output logic       wd_capture,
    output logic       rd_capture
);

    brg_state_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    nxt = acc_write ? ST_WDATA : ST_SETUP;
                end
            end
            ST_WDATA:  nxt = ST_SETUP;
            ST_SETUP:  nxt = ST_ENABLE;
            ST_ENABLE: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready_out  = 1'b0;
        phase_on   = 1'b0;
        strobe     = 1'b0;
        wd_capture = 1'b0;
        rd_capture = 1'b0;
        unique case (state)
            ST_IDLE:  ready_out = 1'b1;
            ST_WDATA: wd_capture = 1'b1;
            ST_SETUP: phase_on = 1'b1;
            ST_ENABLE: begin
                phase_on   = 1'b1;
                strobe     = 1'b1;
                rd_capture = !lat_write;
            end
            default: ready_out = 1'b1;
        endcase
    end

    assert_setup_then_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |=> (state == ST_ENABLE));

    assert_wdata_then_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA) |=> (state == ST_SETUP));

    assert_enable_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENABLE) |=> ready_out);

endmodule

// File: rtl/brg_xfer_latch.sv
module brg_xfer_latch #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] addr_in,
    input  logic          write_in,
    input  logic          wd_capture,
    input  logic [DW-1:0] wdata_in,
    output logic [AW-1:0] lat_addr,
    output logic          lat_write,
    output logic [DW-1:0] lat_wdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_write <= 1'b0;
        end else if (accept) begin
            lat_addr  <= addr_in;
            lat_write <= write_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_wdata <= '0;
        end else if (wd_capture) begin
            lat_wdata <= wdata_in;
        end
    end

    assert_wdata_from_dphase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_capture |=> (lat_wdata == $past(wdata_in)));

endmodule

// File: rtl/brg_sel_decode.sv
module brg_sel_decode #(
    parameter int NPER = 4,
    parameter int IDXW = 2
) (
    input  logic [IDXW-1:0] idx,
    input  logic            active,
    output logic [NPER-1:0] sel
);

    for (genvar k = 0; k < NPER; k++) begin : g_sel
        assign sel[k] = active && (idx == IDXW'(k));
    end

endmodule

// File: rtl/brg_rdata_return.sv
module brg_rdata_return #(
    parameter int DW   = 32,
    parameter int NPER = 4,
    parameter int IDXW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPER*DW-1:0] per_rdata,
    input  logic [IDXW-1:0]    idx,
    input  logic               capture,
    output logic [DW-1:0]      rdata_out
);

    logic [DW-1:0] slice [NPER];
    logic [DW-1:0] picked;

    for (genvar k = 0; k < NPER; k++) begin : g_slice
        assign slice[k] = per_rdata[k*DW +: DW];
    end

    always_comb begin
        picked = '0;
        for (int k = 0; k < NPER; k++) begin
            if (idx == IDXW'(k)) begin
                picked = slice[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_out <= '0;
        end else if (capture) begin
            rdata_out <= picked;
        end
    end

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rdata_out));

endmodule

// File: rtl/ahbl_apb_bridge.sv
module ahbl_apb_bridge
    import ahbl_apb_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int NPER = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_in,
    input  logic [AW-1:0]      addr_in,
    input  logic [1:0]         trans_in,
    input  logic               write_in,
    input  logic [DW-1:0]      wdata_in,
    input  logic               ready_in,
    output logic               ready_out,
    output logic [DW-1:0]      rdata_out,
    output logic [NPER-1:0]    per_sel,
    output logic               per_en,
    output logic               per_write,
    output logic [AW-1:0]      per_addr,
    output logic [DW-1:0]      per_wdata,
    input  logic [NPER*DW-1:0] per_rdata
);

    localparam int IDXW = (NPER > 1) ? $clog2(NPER) : 1;

    brg_state_e      state;
    logic            accept;
    logic            phase_on;
    logic            wd_capture;
    logic            rd_capture;
    logic [IDXW-1:0] idx;

    assign accept = sel_in && ready_in && (state == ST_IDLE)
                 && ((trans_in == TR_NONSEQ) || (trans_in == TR_SEQ));

    assign idx = per_addr[AW-1 -: IDXW];

    brg_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .acc_write  (write_in),
        .lat_write  (per_write),
        .state      (state),
        .ready_out  (ready_out),
        .phase_on   (phase_on),
        .strobe     (per_en),
        .wd_capture (wd_capture),
        .rd_capture (rd_capture)
    );

    brg_xfer_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .addr_in    (addr_in),
        .write_in   (write_in),
        .wd_capture (wd_capture),
        .wdata_in   (wdata_in),
        .lat_addr   (per_addr),
        .lat_write  (per_write),
        .lat_wdata  (per_wdata)
    );

    brg_sel_decode #(.NPER(NPER), .IDXW(IDXW)) u_dec (
        .idx    (idx),
        .active (phase_on),
        .sel    (per_sel)
    );

    brg_rdata_return #(.DW(DW), .NPER(NPER), .IDXW(IDXW)) u_rret (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_rdata (per_rdata),
        .idx       (idx),
        .capture   (rd_capture),
        .rdata_out (rdata_out)
    );

    assert_en_needs_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |-> ($countones(per_sel) == 1));

    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_sel));

    assert_stable_in_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |-> ($stable(per_addr) && $stable(per_write) && $stable(per_wdata)));

    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (per_sel != '0) |-> !ready_out);

    assert_ignore_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_out && !(sel_in && ready_in && trans_in[1])) |=> ready_out);

    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_out && sel_in && ready_in && trans_in[1]) |=> !ready_out);

endmodule

// File: tb/ahbl_apb_bridge_bench.sv
`timescale 1ns/1ps
module ahbl_apb_bridge_bench;

    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int NPER = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sel_in = 1'b0;
    logic [AW-1:0]      addr_in = '0;
    logic [1:0]         trans_in = 2'd0;
    logic               write_in = 1'b0;
    logic [DW-1:0]      wdata_in = '0;
    logic               ready_in;
    logic               ready_low = 1'b0;
    logic               ready_out;
    logic [DW-1:0]      rdata_out;
    logic [NPER-1:0]    per_sel;
    logic               per_en;
    logic               per_write;
    logic [AW-1:0]      per_addr;
    logic [DW-1:0]      per_wdata;
    logic [NPER*DW-1:0] per_rdata = '0;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    logic [DW-1:0] last_rd = '0;

    always #2 clk = ~clk;

    assign ready_in = ready_low ? 1'b0 : ready_out;

    ahbl_apb_bridge #(.AW(AW), .DW(DW), .NPER(NPER)) u_ahbl_apb_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_in    (sel_in),
        .addr_in   (addr_in),
        .trans_in  (trans_in),
        .write_in  (write_in),
        .wdata_in  (wdata_in),
        .ready_in  (ready_in),
        .ready_out (ready_out),
        .rdata_out (rdata_out),
        .per_sel   (per_sel),
        .per_en    (per_en),
        .per_write (per_write),
        .per_addr  (per_addr),
        .per_wdata (per_wdata),
        .per_rdata (per_rdata)
    );

    function automatic logic [NPER-1:0] exp_sel(input logic [AW-1:0] a);
        return NPER'(1) << a[AW-1 -: 2];
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a,
                                             input logic [NPER*DW-1:0] all);
        return all[a[AW-1 -: 2]*DW +: DW];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic idle_cycle();
        sel_in   = 1'b0;
        trans_in = 2'd0;
        @(negedge clk);
        check("R2 idle ready", 64'(ready_out), 64'd1);
        check("R2 idle sel",   64'(per_sel),   64'd0);
    endtask

    // Starts right after a negedge with the bridge ready; ends at the negedge
    // of the completion cycle, so another call is back to back (R11).
    task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] exp_data;
        per_rdata = {$urandom, $urandom, $urandom, $urandom};
        check("R11 ready before offer", 64'(ready_out), 64'd1);
        sel_in   = 1'b1;
        trans_in = ($urandom % 2) ? 2'd3 : 2'd2;
        write_in = wr;
        addr_in  = a;
        @(negedge clk);
        sel_in   = 1'b0;
        trans_in = 2'd0;
        addr_in  = AW'($urandom);
        write_in = ~wr;
        if (wr) begin
            wdata_in = d;
            check("R4 wdata sel low", 64'(per_sel),   64'd0);
            check("R7 wdata ready",   64'(ready_out), 64'd0);
            @(negedge clk);
            wdata_in = DW'($urandom);
        end
        // SETUP
        check("R3 setup sel",    64'(per_sel),   64'(exp_sel(a)));
        check("R6 decode",       64'(per_sel),   64'(exp_sel(a)));
        check("R3 setup enable", 64'(per_en),    64'd0);
        check("R7 setup ready",  64'(ready_out), 64'd0);
        check("R5 setup addr",   64'(per_addr),  64'(a));
        check("R5 setup dir",    64'(per_write), 64'(wr));
        if (wr) check("R9 setup wdata", 64'(per_wdata), 64'(d));
        exp_data = exp_rd(a, per_rdata);
        @(negedge clk);
        // ENABLE
        check("R3 enable sel",    64'(per_sel),   64'(exp_sel(a)));
        check("R3 enable strobe", 64'(per_en),    64'd1);
        check("R7 enable ready",  64'(ready_out), 64'd0);
        check("R5 enable addr",   64'(per_addr),  64'(a));
        check("R5 enable dir",    64'(per_write), 64'(wr));
        if (wr) check("R5 enable wdata", 64'(per_wdata), 64'(d));
        @(negedge clk);
        // completion
        check("R7 ready back", 64'(ready_out), 64'd1);
        check("R3 sel off",    64'(per_sel),   64'd0);
        check("R3 strobe off", 64'(per_en),    64'd0);
        if (!wr) last_rd = exp_data;
        check("R8 rdata", 64'(rdata_out), 64'(last_rd));
    endtask

    task automatic ignored_offer(input string why, input logic s, input logic [1:0] t, input logic rl);
        sel_in    = s;
        trans_in  = t;
        write_in  = 1'b0;
        addr_in   = AW'($urandom);
        ready_low = rl;
        @(negedge clk);
        ready_low = 1'b0;
        sel_in    = 1'b0;
        trans_in  = 2'd0;
        check({"R2 ignored ready ", why}, 64'(ready_out), 64'd1);
        check({"R2 ignored sel ", why},   64'(per_sel),   64'd0);
        @(negedge clk);
        check({"R2 still idle ", why},    64'(per_sel),   64'd0);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 ready",  64'(ready_out), 64'd1);
        check("R1 sel",    64'(per_sel),   64'd0);
        check("R1 strobe", 64'(per_en),    64'd0);
        check("R1 rdata",  64'(rdata_out), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        ignored_offer("idle trans", 1'b1, 2'd0, 1'b0);
        ignored_offer("busy trans", 1'b1, 2'd1, 1'b0);
        ignored_offer("no select",  1'b0, 2'd2, 1'b0);
        ignored_offer("ready low",  1'b1, 2'd2, 1'b1);

        // Directed: every select line, read and write
        for (int k = 0; k < NPER; k++) begin
            xfer(1'b0, AW'((k << (AW - 2)) | 16'h0123), '0);
            idle_cycle();
            xfer(1'b1, AW'((k << (AW - 2)) | 16'h00fc), DW'($urandom));
        end
        // Back to back: write then read then write with no gap (R11)
        xfer(1'b1, 16'hffff, 32'hdead_beef);
        xfer(1'b0, 16'h0000, '0);
        xfer(1'b1, 16'h8004, 32'h1234_5678);
        idle_cycle();

        // Random mix
        for (int n = 0; n < 60; n++) begin
            xfer(1'($urandom), AW'($urandom), DW'($urandom));
            for (int g = 0; g < int'($urandom % 3); g++) idle_cycle();
        end

        report();
    end

endmodule